// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects the completion and fault events of a group of DMA channels and turns them into one interrupt line plus a set of registers software can read. Every channel drives three single-cycle event inputs: a terminal-count (transfer done) pulse and two independent error pulses, error class A and error class B. Each class has its own sticky raw register, its own enable register and a masked view. A summary word ORs the three masked views per channel, and the interrupt output is high whenever any summary bit is set. Raw bits are cleared by writing ones to them.

The block also reflects each channel's busy level in a read-only busy word and holds a channel priority value for the channels to use. Software reads the summary word, services the set bits from the lowest bit upward, then clears the matching raw bits. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is a combinational function of `reg_addr_i` and the current register state. The register port has no handshake and no back-pressure: every write is accepted in the cycle it is presented, and the read data is valid in that same cycle. The event and busy inputs are plain levels sampled at every rising edge.

Top module: `dma_irq_agg`

## Requirements
- R1: A high bit on `evt_tc_i`, `evt_ea_i` or `evt_eb_i` sets the matching channel bit of that class's raw register (terminal count at 0x600, error A at 0x608, error B at 0x610) at the next rising edge. The bit stays set until it is cleared, and all raw bits reset to 0.
- R2: A write to a raw register clears every bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R3: If an event and a clearing write hit the same raw bit in the same cycle, the event wins and the bit ends up set.
- R4: The enable registers for terminal count, error A and error B sit at 0x018, 0x020 and 0x024. They read back what was written (bit n = channel n) and reset to 0. The masked status words at 0x004, 0x00C and 0x010 read raw AND enable, so a 1 enables a source and a 0 blocks it.
- R5: Raw bits keep latching events while their source is disabled. Disabling changes only the masked views, the summary and `irq_o`.
- R6: Summary bit n at 0x000 is 1 exactly when channel n has any of its three masked sources set.
- R7: `irq_o` is high exactly when any summary bit is set. It stays high until every enabled raw bit has been cleared or disabled.
- R8: The busy word at 0x690 reads `busy_i` directly, one bit per channel.
- R9: The priority register at 0x688 holds the full `DATA_W`-bit value written to it and resets to 0.
- R10: Writes to the summary word, the masked status words, the busy word or an unmapped address change no register. Unmapped addresses read 0.
- R11: Channel-wide registers hold only `NUM_CH` bits. The bits above them read 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_tc_i | input | NUM_CH | Terminal-count event pulses, one per channel |
| evt_ea_i | input | NUM_CH | Error class A event pulses |
| evt_eb_i | input | NUM_CH | Error class B event pulses |
| busy_i | input | NUM_CH | Channel busy levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A raw bit that drops early, stays stuck or ignores its clear changes the read value of the raw word, and also the summary word and `irq_o` while that source is enabled. Every such error is visible at the first clock edge after it happens. The bench runs a behavioural model in parallel and compares `irq_o` and the read data for the current address on every cycle, so a bad enable bit or a summary bit on the wrong channel is caught within one cycle of the register being addressed. The event-against-clear collision is driven on purpose, and it is also hit during the random phase.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int REG_AW  = 12;
  localparam int NUM_SRC = 3;  // terminal count, error A, error B

  typedef logic [REG_AW-1:0] reg_addr_t;

  // Source index order: 0 = terminal count, 1 = error A, 2 = error B
  localparam reg_addr_t OFS_SUMMARY = 12'h000;
  localparam reg_addr_t OFS_PRIO    = 12'h688;
  localparam reg_addr_t OFS_BUSY    = 12'h690;

  localparam reg_addr_t OFS_STAT [NUM_SRC] = '{12'h004, 12'h00C, 12'h010};
  localparam reg_addr_t OFS_MASK [NUM_SRC] = '{12'h018, 12'h020, 12'h024};
  localparam reg_addr_t OFS_RAW  [NUM_SRC] = '{12'h600, 12'h608, 12'h610};

endpackage

// File: rtl/dma_irq_src_bank.sv
// One event class: sticky raw latch with write-one-to-clear, enable
// register and masked view.
module dma_irq_src_bank
  import dma_irq_pkg::*;
#(
  parameter int        NUM_CH    = 16,
  parameter reg_addr_t RAW_ADDR  = 12'h600,
  parameter reg_addr_t MASK_ADDR = 12'h018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              wr_i,
  input  reg_addr_t         addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] masked_o
);

  logic              raw_hit;
  logic              mask_hit;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] raw_q;
  logic [NUM_CH-1:0] mask_q;

  assign raw_hit  = wr_i && (addr_i == RAW_ADDR);
  assign mask_hit = wr_i && (addr_i == MASK_ADDR);
  assign clr_vec  = raw_hit ? wdata_i : '0;

  // Per-channel latch: event set dominates clear
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[ch] <= 1'b0;
      end else if (evt_i[ch]) begin
        raw_q[ch] <= 1'b1;
      end else if (clr_vec[ch]) begin
        raw_q[ch] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_hit) begin
      mask_q <= wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;

endmodule

// File: rtl/dma_irq_rd_mux.sv
// Combinational register read selection, zero-extended to DATA_W.
module dma_irq_rd_mux
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  reg_addr_t         addr_i,
  input  logic [NUM_CH-1:0] summary_i,
  input  logic [NUM_CH-1:0] masked_i [NUM_SRC],
  input  logic [NUM_CH-1:0] raw_i    [NUM_SRC],
  input  logic [NUM_CH-1:0] mask_i   [NUM_SRC],
  input  logic [NUM_CH-1:0] busy_i,
  input  logic [DATA_W-1:0] prio_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_SUMMARY: rdata_o = DATA_W'(summary_i);
      OFS_STAT[0]: rdata_o = DATA_W'(masked_i[0]);
      OFS_STAT[1]: rdata_o = DATA_W'(masked_i[1]);
      OFS_STAT[2]: rdata_o = DATA_W'(masked_i[2]);
      OFS_MASK[0]: rdata_o = DATA_W'(mask_i[0]);
      OFS_MASK[1]: rdata_o = DATA_W'(mask_i[1]);
      OFS_MASK[2]: rdata_o = DATA_W'(mask_i[2]);
      OFS_RAW[0]:  rdata_o = DATA_W'(raw_i[0]);
      OFS_RAW[1]:  rdata_o = DATA_W'(raw_i[1]);
      OFS_RAW[2]:  rdata_o = DATA_W'(raw_i[2]);
      OFS_PRIO:    rdata_o = prio_i;
      OFS_BUSY:    rdata_o = DATA_W'(busy_i);
      default:     rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_tc_i,
  input  logic [NUM_CH-1:0] evt_ea_i,
  input  logic [NUM_CH-1:0] evt_eb_i,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] evt_all    [NUM_SRC];
  logic [NUM_CH-1:0] raw_all    [NUM_SRC];
  logic [NUM_CH-1:0] mask_all   [NUM_SRC];
  logic [NUM_CH-1:0] masked_all [NUM_SRC];
  logic [NUM_CH-1:0] summary;
  logic [DATA_W-1:0] prio_q;

  assign evt_all[0] = evt_tc_i;
  assign evt_all[1] = evt_ea_i;
  assign evt_all[2] = evt_eb_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    dma_irq_src_bank #(
      .NUM_CH   (NUM_CH),
      .RAW_ADDR (OFS_RAW[g]),
      .MASK_ADDR(OFS_MASK[g])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_all[g]),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i[NUM_CH-1:0]),
      .raw_o   (raw_all[g]),
      .mask_o  (mask_all[g]),
      .masked_o(masked_all[g])
    );
  end

  always_comb begin
    summary = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      summary = summary | masked_all[k];
    end
  end

  assign irq_o = |summary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (reg_wr_i && (reg_addr_i == OFS_PRIO)) begin
      prio_q <= reg_wdata_i;
    end
  end

  dma_irq_rd_mux #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) u_rd_mux (
    .addr_i   (reg_addr_i),
    .summary_i(summary),
    .masked_i (masked_all),
    .raw_i    (raw_all),
    .mask_i   (mask_all),
    .busy_i   (busy_i),
    .prio_i   (prio_q),
    .rdata_o  (reg_rdata_o)
  );

endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] evt_tc_i,
  input logic [NUM_CH-1:0] evt_ea_i,
  input logic              reg_wr_i,
  input logic [11:0]       reg_addr_i,
  input logic [NUM_CH-1:0] wdata_lo,
  input logic [NUM_CH-1:0] raw_tc,
  input logic [NUM_CH-1:0] raw_ea,
  input logic [NUM_CH-1:0] raw_eb,
  input logic [NUM_CH-1:0] mask_tc,
  input logic [NUM_CH-1:0] mask_ea,
  input logic [NUM_CH-1:0] mask_eb,
  input logic              irq_o
);

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tc_i != '0) |=> ((raw_tc & $past(evt_tc_i)) == $past(evt_tc_i))); // R1

  AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 12'h608 && evt_ea_i != '0)
      |=> ((raw_ea & $past(evt_ea_i)) == $past(evt_ea_i))); // R3

  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && evt_tc_i == '0) |=> $stable(raw_tc)); // R2

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 12'h600 && evt_tc_i == '0)
      |=> ((raw_tc & $past(wdata_lo)) == '0)); // R2

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 12'h018) |=> (mask_tc == $past(wdata_lo))); // R4

  AST_IRQ_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|((raw_tc & mask_tc) | (raw_ea & mask_ea) | (raw_eb & mask_eb)))); // R7

endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_tc_i  (evt_tc_i),
  .evt_ea_i  (evt_ea_i),
  .reg_wr_i  (reg_wr_i),
  .reg_addr_i(reg_addr_i),
  .wdata_lo  (reg_wdata_i[NUM_CH-1:0]),
  .raw_tc    (raw_all[0]),
  .raw_ea    (raw_all[1]),
  .raw_eb    (raw_all[2]),
  .mask_tc   (mask_all[0]),
  .mask_ea   (mask_all[1]),
  .mask_eb   (mask_all[2]),
  .irq_o     (irq_o)
);

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] evt_tc = '0, evt_ea = '0, evt_eb = '0, busy = '0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_agg u_dma_irq_agg (
    .clk(clk), .rst_n(rst_n), .evt_tc_i(evt_tc), .evt_ea_i(evt_ea),
    .evt_eb_i(evt_eb), .busy_i(busy), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  // Behavioural reference state
  logic [NCH-1:0] m_raw  [3];
  logic [NCH-1:0] m_mask [3];
  logic [31:0]    m_prio;

  function automatic logic [11:0] raw_addr(int k);
    return (k == 0) ? 12'h600 : (k == 1) ? 12'h608 : 12'h610;
  endfunction
  function automatic logic [11:0] mask_addr(int k);
    return (k == 0) ? 12'h018 : (k == 1) ? 12'h020 : 12'h024;
  endfunction
  function automatic logic [11:0] stat_addr(int k);
    return (k == 0) ? 12'h004 : (k == 1) ? 12'h00C : 12'h010;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] r;
    logic [31:0] sum;
    r = 0;
    sum = 0;
    for (int k = 0; k < 3; k++) sum = sum | 32'(m_raw[k] & m_mask[k]);
    if (a == 12'h000) r = sum;
    if (a == 12'h688) r = m_prio;
    if (a == 12'h690) r = 32'(busy);
    for (int k = 0; k < 3; k++) begin
      if (a == stat_addr(k)) r = 32'(m_raw[k] & m_mask[k]);
      if (a == mask_addr(k)) r = 32'(m_mask[k]);
      if (a == raw_addr(k))  r = 32'(m_raw[k]);
    end
    return r;
  endfunction

  function automatic logic m_irq();
    return m_read(12'h000) != 0;
  endfunction

  always @(posedge clk) begin
    logic [NCH-1:0] ev [3];
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        m_raw[k]  = '0;
        m_mask[k] = '0;
      end
      m_prio = '0;
    end else begin
      ev[0] = evt_tc; ev[1] = evt_ea; ev[2] = evt_eb;
      for (int k = 0; k < 3; k++) begin
        for (int b = 0; b < NCH; b++) begin
          if (ev[k][b]) m_raw[k][b] = 1'b1;
          else if (reg_wr && reg_addr == raw_addr(k) && reg_wdata[b]) m_raw[k][b] = 1'b0;
        end
        if (reg_wr && reg_addr == mask_addr(k)) m_mask[k] = reg_wdata[NCH-1:0];
      end
      if (reg_wr && reg_addr == 12'h688) m_prio = reg_wdata;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "irq vs model", 32'(irq), 32'(m_irq()));
      chk(cur_req, "rdata vs model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic drive(logic [NCH-1:0] tc, logic [NCH-1:0] ea, logic [NCH-1:0] eb,
                       logic wr, logic [11:0] a, logic [31:0] wd);
    @(negedge clk);
    #1;
    evt_tc = tc; evt_ea = ea; evt_eb = eb;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] wd);
    drive('0, '0, '0, 1'b1, a, wd);
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    drive('0, '0, '0, 1'b0, a, '0);
    #1;
    chk(req, $sformatf("read %h", a), reg_rdata, exp);
  endtask

  task automatic irq_chk(string req, logic exp);
    #1;
    chk(req, "irq", 32'(irq), 32'(exp));
  endtask

  function automatic logic [11:0] pick_addr(int n);
    case (n)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h00C;
      3: return 12'h010;  4: return 12'h018;  5: return 12'h020;
      6: return 12'h024;  7: return 12'h600;  8: return 12'h608;
      9: return 12'h610;  10: return 12'h688; 11: return 12'h690;
      default: return 12'h100;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    cur_req = "R4";
    rd_chk("R4", 12'h018, 32'h0);
    cur_req = "R9";
    rd_chk("R9", 12'h688, 32'h0);
    cur_req = "R1";
    rd_chk("R1", 12'h600, 32'h0);
    irq_chk("R7", 1'b0);

    // R1: latching
    drive(16'h0005, 16'h0100, 16'h8000, 1'b0, 12'h000, '0);
    rd_chk("R1", 12'h600, 32'h0005);
    rd_chk("R1", 12'h608, 32'h0100);
    rd_chk("R1", 12'h610, 32'h8000);

    // R5: disabled sources still latched, no interrupt
    cur_req = "R5";
    rd_chk("R5", 12'h004, 32'h0);
    irq_chk("R5", 1'b0);

    // R4: enable one bit
    cur_req = "R4";
    wr_reg(12'h018, 32'h0001);
    rd_chk("R4", 12'h018, 32'h0001);
    rd_chk("R4", 12'h004, 32'h0001);
    irq_chk("R7", 1'b1);

    // R6: summary
    cur_req = "R6";
    wr_reg(12'h020, 32'hFFFF);
    wr_reg(12'h024, 32'hFFFF);
    rd_chk("R6", 12'h000, 32'h8101);
    wr_reg(12'h018, 32'hFFFF);
    rd_chk("R6", 12'h000, 32'h8105);

    // R2: write one to clear
    cur_req = "R2";
    wr_reg(12'h600, 32'h0004);
    rd_chk("R2", 12'h600, 32'h0001);
    wr_reg(12'h608, 32'h0000);
    rd_chk("R2", 12'h608, 32'h0100);

    // R3: event beats clear on the same bit
    cur_req = "R3";
    drive('0, 16'h0200, '0, 1'b1, 12'h608, 32'h0300);
    rd_chk("R3", 12'h608, 32'h0200);

    // R7: interrupt holds until all enabled bits cleared
    cur_req = "R7";
    wr_reg(12'h600, 32'hFFFF);
    wr_reg(12'h608, 32'hFFFF);
    rd_chk("R7", 12'h000, 32'h8000);
    irq_chk("R7", 1'b1);
    wr_reg(12'h610, 32'hFFFF);
    rd_chk("R7", 12'h000, 32'h0);
    irq_chk("R7", 1'b0);

    // R5: masked class keeps latching; unmask reveals it
    cur_req = "R5";
    wr_reg(12'h020, 32'h0);
    drive('0, 16'h0010, '0, 1'b0, 12'h000, '0);
    rd_chk("R5", 12'h608, 32'h0010);
    rd_chk("R5", 12'h00C, 32'h0);
    irq_chk("R5", 1'b0);
    wr_reg(12'h020, 32'hFFFF);
    rd_chk("R5", 12'h00C, 32'h0010);
    irq_chk("R5", 1'b1);
    wr_reg(12'h608, 32'h0010);

    // R8: busy mirror
    cur_req = "R8";
    busy = 16'hA5A5;
    rd_chk("R8", 12'h690, 32'h0000A5A5);

    // R9: priority register
    cur_req = "R9";
    wr_reg(12'h688, 32'h12345678);
    rd_chk("R9", 12'h688, 32'h12345678);

    // R10: read-only and unmapped writes have no effect
    cur_req = "R10";
    wr_reg(12'h690, 32'hFFFF);
    wr_reg(12'h000, 32'hFFFF);
    wr_reg(12'h004, 32'hFFFF);
    wr_reg(12'h100, 32'hFFFF);
    rd_chk("R10", 12'h100, 32'h0);
    rd_chk("R10", 12'h690, 32'h0000A5A5);
    rd_chk("R10", 12'h688, 32'h12345678);
    rd_chk("R10", 12'h018, 32'h0000FFFF);
    rd_chk("R10", 12'h600, 32'h0);

    // R11: upper bits read zero
    cur_req = "R11";
    wr_reg(12'h020, 32'hFFFFFFFF);
    rd_chk("R11", 12'h020, 32'h0000FFFF);

    // Random traffic compared against the model every cycle
    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      logic [NCH-1:0] t, a, b;
      t = NCH'($urandom) & NCH'($urandom);
      a = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      b = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      if (i % 50 == 0) busy = NCH'($urandom);
      drive(t, a, b, ($urandom % 3) == 0, pick_addr($urandom % 13), $urandom);
    end
    drive('0, '0, '0, 1'b0, 12'h000, '0);
    @(negedge clk);
    #1 done = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule